// File: doc/BRIEF.md
# Serial Wiper Step Controller

This block moves a digital potentiometer's wiper one tap at a time from the serial bus clock. A command decoder elsewhere recognises the step instruction. Once that instruction has been acknowledged, the decoder pulses `step_en_i` together with the pot number. From then on, every high pulse of the bus clock line is a single step command. The level of the data line during that pulse sets the direction: high moves toward the top tap and low moves toward the bottom tap. Any mix of up and down pulses is accepted until a stop condition ends the mode.

The block reads the current wiper values of all pots from the wiper register bank on `wiper_i`. It returns a one-cycle update (`upd_vld_o`, `upd_sel_o`, `upd_val_o`) and a direction strobe (`step_up_o` or `step_dn_o`) for each accepted step. The bank writes that update into the selected wiper register. Both bus inputs are expected to be synchronised to `clk` already. The block never drives the data line.

A pulse counts when it is complete, so the controller works as follows. It records the data level at the clock's rising edge. It commits the step at the falling edge only if the data line stayed steady while the clock was high. This keeps the clock rise that comes just before a stop from being taken as a down step.

There are four states:
- `ST_IDLE`: waits for `step_en_i`, then moves to `ST_WAIT_LOW`.
- `ST_WAIT_LOW`: waits for the clock line to be low, then moves to `ST_ARMED`.
- `ST_ARMED`: on a clock rise, moves to `ST_HIGH` and latches the direction.
- `ST_HIGH`: has three exits:
  - a data rise (stop) returns to `ST_IDLE`;
  - a data fall (start) abandons the pulse and returns to `ST_WAIT_LOW`;
  - a clock fall commits the step and returns to `ST_ARMED`.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset `upd_vld_o`, `step_up_o` and `step_dn_o` are 0 and the controller is in `ST_IDLE`.
- R2: Clock pulses given while the step mode has not been entered produce no update and no strobe.
- R3: `step_en_i` latches `pot_sel_i` as the target pot. A clock high phase already in progress when the mode is entered is not counted. Counting starts with the first clock rise after the line has been seen low.
- R4: A complete clock high pulse with the data line held at 1 raises the target wiper by one. One cycle after the clock fall is seen, `step_up_o` and `upd_vld_o` are 1 for one cycle, with `upd_val_o` equal to the old value plus 1.
- R5: A complete clock high pulse with the data line held at 0 lowers the target wiper by one. `step_dn_o` and `upd_vld_o` pulse in the same cycle as in R4, with `upd_val_o` equal to the old value minus 1.
- R6: The wiper saturates at 0 and at 255 (8-bit value). An up pulse at 255 or a down pulse at 0 produces no update and no strobe.
- R7: Updates carry the latched pot number on `upd_sel_o` (pot 0 is value 0). The wiper of any other pot is never changed.
- R8: A data rise while the clock is high (stop) produces no step and ends the mode. Later clock pulses are ignored until `step_en_i` is given again.
- R9: A data fall while the clock is high (start) cancels that pulse without a step. The mode stays active, and the next complete pulse steps normally.
- R10: Any number of up and down pulses may be mixed in one mode session, and each is applied to the value left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| step_en_i | input | 1 | One-cycle pulse from the decoder: step instruction acknowledged |
| pot_sel_i | input | 1 | Pot number for the step session, sampled with `step_en_i` |
| wiper_i | input | 16 | Current wiper values, pot n in bits [8n+7:8n] |
| step_up_o | output | 1 | One-cycle strobe: an up step was accepted |
| step_dn_o | output | 1 | One-cycle strobe: a down step was accepted |
| upd_vld_o | output | 1 | One-cycle write strobe for the wiper bank |
| upd_sel_o | output | 1 | Pot whose wiper is written |
| upd_val_o | output | 8 | New wiper value |

## Verification
The hardest case to reach from the ports is a clock high phase that ends in something other than a plain falling edge. This covers a data rise (stop) and a data fall (start) while the clock is high. It also covers a high phase that was already running when the mode was entered. The bench reaches each case by driving the two bus lines one cycle apart, in the exact order a master would use. It then checks that no update appears in the cycle after the clock fall. Saturation is reached by presetting the bench's own wiper bank to 254 and to 1 before the session.

// File: rtl/wstep_pkg.sv
package wstep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_LOW = 2'd1,
        ST_ARMED    = 2'd2,
        ST_HIGH     = 2'd3
    } wstep_state_e;

endpackage

// File: rtl/wstep_edges.sv
module wstep_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_rise,
    output logic sda_fall
);
    logic scl_q;
    logic sda_q;

    // Both lines idle high on a released bus.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise = scl_i & ~scl_q;
    assign scl_fall = ~scl_i & scl_q;
    assign sda_rise = sda_i & ~sda_q;
    assign sda_fall = ~sda_i & sda_q;

endmodule

// File: rtl/wstep_sat.sv
module wstep_sat #(
    parameter int unsigned NPOT  = 2,
    parameter int unsigned WIDTH = 8,
    parameter int unsigned SELW  = 1
) (
    input  logic [NPOT*WIDTH-1:0] wiper_flat,
    input  logic [SELW-1:0]       sel,
    input  logic                  dir_up,
    output logic [WIDTH-1:0]      next_val,
    output logic                  at_limit
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] wipers [NPOT];
    logic [WIDTH-1:0] cur;

    for (genvar g = 0; g < NPOT; g++) begin : g_unpack
        assign wipers[g] = wiper_flat[g*WIDTH +: WIDTH];
    end

    always_comb begin
        cur = wipers[0];
        for (int i = 0; i < NPOT; i++) begin
            if (sel == SELW'(i)) cur = wipers[i];
        end
    end

    always_comb begin
        if (dir_up) begin
            at_limit = (cur == TOP);
            next_val = at_limit ? cur : cur + WIDTH'(1);
        end else begin
            at_limit = (cur == '0);
            next_val = at_limit ? cur : cur - WIDTH'(1);
        end
    end

endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl #(
    parameter int unsigned NPOT  = 2,
    parameter int unsigned WIDTH = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                scl_i,
    input  logic                                sda_i,
    input  logic                                step_en_i,
    input  logic [((NPOT>1)?$clog2(NPOT):1)-1:0] pot_sel_i,
    input  logic [NPOT*WIDTH-1:0]               wiper_i,
    output logic                                step_up_o,
    output logic                                step_dn_o,
    output logic                                upd_vld_o,
    output logic [((NPOT>1)?$clog2(NPOT):1)-1:0] upd_sel_o,
    output logic [WIDTH-1:0]                    upd_val_o
);
    import wstep_pkg::*;

    localparam int unsigned      SELW = (NPOT > 1) ? $clog2(NPOT) : 1;
    localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

    wstep_state_e     state_q, state_d;
    logic [SELW-1:0]  sel_q;
    logic             dir_q;
    logic             scl_rise, scl_fall, sda_rise, sda_fall;
    logic [WIDTH-1:0] next_val;
    logic             at_limit;
    logic             commit;

    wstep_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_rise (sda_rise),
        .sda_fall (sda_fall)
    );

    wstep_sat #(
        .NPOT  (NPOT),
        .WIDTH (WIDTH),
        .SELW  (SELW)
    ) u_sat (
        .wiper_flat (wiper_i),
        .sel        (sel_q),
        .dir_up     (dir_q),
        .next_val   (next_val),
        .at_limit   (at_limit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (step_en_i) state_d = ST_WAIT_LOW;
            ST_WAIT_LOW: if (!scl_i)    state_d = ST_ARMED;
            ST_ARMED:    if (scl_rise)  state_d = ST_HIGH;
            ST_HIGH: begin
                if (sda_rise)      state_d = ST_IDLE;      // stop ends mode
                else if (sda_fall) state_d = ST_WAIT_LOW;  // start cancels pulse
                else if (scl_fall) state_d = ST_ARMED;     // pulse complete
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    assign commit = (state_q == ST_HIGH) && scl_fall && !sda_rise && !sda_fall;

    // State register with session context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && step_en_i) sel_q <= pot_sel_i;
            if (state_q == ST_ARMED && scl_rise) dir_q <= sda_i;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_up_o <= 1'b0;
            step_dn_o <= 1'b0;
            upd_vld_o <= 1'b0;
            upd_sel_o <= '0;
            upd_val_o <= '0;
        end else begin
            step_up_o <= 1'b0;
            step_dn_o <= 1'b0;
            upd_vld_o <= 1'b0;
            if (commit && !at_limit) begin
                step_up_o <= dir_q;
                step_dn_o <= !dir_q;
                upd_vld_o <= 1'b1;
                upd_sel_o <= sel_q;
                upd_val_o <= next_val;
            end
        end
    end

    // R2: no update can follow a cycle spent outside the mode
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !upd_vld_o);

    // R4/R5: a step has exactly one direction
    p_dir_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up_o && step_dn_o));

    // R6: an up step never lands on 0
    p_no_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_up_o |-> (upd_val_o != '0));

    // R6: a down step never lands on the top tap
    p_no_wrap_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn_o |-> (upd_val_o != MAXV));

    // R8: a stop while the clock is high leaves the mode
    p_stop_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && sda_rise) |=> (state_q == ST_IDLE));

endmodule

// File: tb/wiper_step_ctrl_tb.sv
module wiper_step_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       step_en = 1'b0;
    logic       pot_sel = 1'b0;
    logic [7:0] wcr [2];
    logic [15:0] wiper;
    logic       step_up, step_dn, upd_vld, upd_sel;
    logic [7:0] upd_val;
    int         checks = 0;
    int         errors = 0;
    int         expv [2];
    bit         done = 0;

    always #10 clk = ~clk;

    assign wiper = {wcr[1], wcr[0]};

    wiper_step_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda),
        .step_en_i (step_en),
        .pot_sel_i (pot_sel),
        .wiper_i   (wiper),
        .step_up_o (step_up),
        .step_dn_o (step_dn),
        .upd_vld_o (upd_vld),
        .upd_sel_o (upd_sel),
        .upd_val_o (upd_val)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic enter(input bit pot);
        pot_sel = pot; step_en = 1'b1; tick();
        step_en = 1'b0; tick();
    endtask

    // One full clock pulse; active=0 means the pulse must be ignored.
    task automatic pulse(input bit up, input bit active, input string req);
        int  pot;
        int  cur;
        bit  moved;
        int  nv;
        pot = pot_sel;
        cur = expv[pot];
        moved = active && (up ? (cur < 255) : (cur > 0));
        nv = up ? cur + 1 : cur - 1;
        sda = up; tick();
        scl = 1'b1; tick(); tick();
        scl = 1'b0; tick();
        chk(upd_vld == moved, req, upd_vld, moved);
        chk(step_up == (moved && up) && step_dn == (moved && !up), req,
            {step_up, step_dn}, {moved && up, moved && !up});
        if (moved) begin
            chk(upd_val == nv[7:0] && upd_sel == pot[0], req, upd_val, nv);
            expv[pot] = nv;
        end
        if (upd_vld) wcr[upd_sel] = upd_val;
        tick();
    endtask

    task automatic stop_cond();
        int bad = 0;
        scl = 1'b0; tick(); if (upd_vld) bad++;
        sda = 1'b0; tick(); if (upd_vld) bad++;
        scl = 1'b1; tick(); if (upd_vld) bad++;
        tick();             if (upd_vld) bad++;
        sda = 1'b1; tick(); if (upd_vld) bad++;
        tick();             if (upd_vld) bad++;
        scl = 1'b0; tick(); if (upd_vld) bad++;
        tick();             if (upd_vld) bad++;
        chk(bad == 0, "R8 stop gives no step", bad, 0);
    endtask

    task automatic t_reset();
        chk(!upd_vld && !step_up && !step_dn, "R1 reset outputs",
            {upd_vld, step_up, step_dn}, 0);
    endtask

    task automatic t_idle_ignored();
        pot_sel = 1'b0;
        pulse(1'b1, 1'b0, "R2 idle up ignored");
        pulse(1'b0, 1'b0, "R2 idle down ignored");
        chk(wcr[0] == 8'd128, "R2 wiper unchanged", wcr[0], 128);
    endtask

    task automatic t_entry_mid_high();
        scl = 1'b1; sda = 1'b1; tick();
        enter(1'b0);
        tick();
        scl = 1'b0; tick();
        chk(!upd_vld, "R3 high phase at entry not counted", upd_vld, 0);
        tick();
    endtask

    task automatic t_up_down_mix();
        pulse(1'b1, 1'b1, "R4 up step");
        pulse(1'b1, 1'b1, "R4 up step");
        pulse(1'b1, 1'b1, "R4 up step");
        chk(wcr[0] == 8'd131, "R4 value after three ups", wcr[0], 131);
        pulse(1'b0, 1'b1, "R5 down step");
        pulse(1'b0, 1'b1, "R5 down step");
        chk(wcr[0] == 8'd129, "R5 value after two downs", wcr[0], 129);
        pulse(1'b1, 1'b1, "R10 mixed");
        pulse(1'b0, 1'b1, "R10 mixed");
        pulse(1'b0, 1'b1, "R10 mixed");
        pulse(1'b1, 1'b1, "R10 mixed");
        pulse(1'b1, 1'b1, "R10 mixed");
        chk(wcr[0] == 8'd130, "R10 value after mixed run", wcr[0], 130);
    endtask

    task automatic t_start_cancel();
        sda = 1'b1; tick();
        scl = 1'b1; tick(); tick();
        sda = 1'b0; tick();
        scl = 1'b0; tick();
        chk(!upd_vld, "R9 start cancels pulse", upd_vld, 0);
        tick();
        pulse(1'b1, 1'b1, "R9 mode kept after start");
    endtask

    task automatic t_stop_then_ignored();
        stop_cond();
        pulse(1'b1, 1'b0, "R8 pulse after stop ignored");
        pulse(1'b0, 1'b0, "R8 pulse after stop ignored");
    endtask

    task automatic t_top_sat();
        wcr[1] = 8'd254; expv[1] = 254;
        enter(1'b1);
        pulse(1'b1, 1'b1, "R6 step to 255");
        pulse(1'b1, 1'b1, "R6 saturate at 255");
        chk(wcr[1] == 8'd255, "R6 top value", wcr[1], 255);
        chk(wcr[0] == expv[0][7:0], "R7 other pot untouched", wcr[0], expv[0]);
        stop_cond();
    endtask

    task automatic t_bottom_sat();
        wcr[1] = 8'd1; expv[1] = 1;
        enter(1'b1);
        pulse(1'b0, 1'b1, "R6 step to 0");
        pulse(1'b0, 1'b1, "R6 saturate at 0");
        pulse(1'b1, 1'b1, "R7 pot1 up");
        chk(wcr[1] == 8'd1 && wcr[0] == expv[0][7:0], "R7 only pot1 moved",
            wcr[1], 1);
        stop_cond();
    endtask

    initial begin
        wcr[0] = 8'd128; wcr[1] = 8'd254;
        expv[0] = 128; expv[1] = 254;
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1; tick();
        t_reset();
        t_idle_ignored();
        t_entry_mid_high();
        t_up_down_mix();
        t_start_cancel();
        t_stop_then_ignored();
        t_top_sat();
        t_bottom_sat();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule